// File: doc/BRIEF.md
# Register-Sequenced I2C Bus Master

This block is a two-wire bus master that a processor steps through one bus action at a time. Software writes a command word into a control register: a START condition, a byte transfer, or a STOP condition. Each write launches exactly one action. When the action is finished, the block raises a completion flag and an interrupt line. It also posts a status code that software reads to decide what to do next.

The clock line and the data line are driven open-drain. The block only ever pulls a line low or lets it go. The first byte after each START is treated as the slave address, and its lowest bit sets the direction for the bytes that follow. After every START and every byte the block holds the clock line low until software issues the next command.

There are four 8-bit registers, selected by a 2-bit address:

| Address | Register | Contents |
|---|---|---|
| 0 | Control | flag bit 7, acknowledge-enable bit 6, START bit 5, STOP bit 4, enable bit 2 |
| 1 | Status | status code in bits 7:3 (bit 2 reads as 0), prescaler select in bits 1:0 |
| 2 | Data | byte to send, or the last byte received |
| 3 | Bit rate | divider value `br` |

Top module: `i2c_cmd_master`

## Requirements
- R1: A write to the control register (address 0) launches a bus action only when the written byte has both bit 7 (flag) and bit 2 (enable) set to 1. A write with either bit at 0 causes no bus activity. Any control write with bit 7 set clears the completion flag, which reads back as control bit 7 and drives `irq_o`.
- R2: The bus action starts in the cycle after the launching write. The byte sent is the data register (address 2) content at the time of the launching write, even if the data register is written again in the very next cycle.
- R3: When several request bits are set in one launching write, START (bit 5) wins over STOP (bit 4), and STOP wins over a byte transfer.
- R4: A read of the status register (address 1) returns the status code in bits 7:3, 0 in bit 2, and the written prescaler select in bits 1:0. After reset the code is 0xF8, the idle code.
- R5: A completed START posts code 0x08 if the status was idle when the START was launched. Otherwise it posts 0x10, which marks a repeated START.
- R6: The first byte after a START is the address: slave address in bits 7:1, direction in bit 0 (0 = write). The posted code is 0x18 for a write address that is acknowledged and 0x20 for one that is not. It is 0x40 for a read address that is acknowledged and 0x48 for one that is not.
- R7: A data byte sent in write direction is sent most significant bit first. The posted code is 0x28 if the slave acknowledges it and 0x30 if it does not.
- R8: In read direction the block receives one byte, most significant bit first, and stores it in the data register. If control bit 6 was set in the launching write, the block answers with ACK and posts 0x50. Otherwise it answers with NACK and posts 0x58.
- R9: A completed STOP posts 0xF8, sets the flag, and leaves both bus lines released.
- R10: The flag is set at the end of every bus action. While the flag is set after a START or a byte, the clock line is held low.
- R11: The clock line period is 4 × (4 + floor(br × 4^ps / 2)) system clock cycles, where `br` is the bit-rate register and `ps` is the prescaler select.
- R12: During byte transfers the data line changes only while the clock line is low. It changes with the clock line high only to form START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Completion flag |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | Pull the clock line low when 1 |
| sda_oe_o | output | 1 | Pull the data line low when 1 |

## Verification
Two functions can meet on the same clock edge: the engine loading its byte snapshot, and a new write to the data register. The engine loads its byte one edge after the launching control write. The bench therefore writes a new value into the data register on exactly that edge, while a data byte is pending. It then judges, through a bus-watching slave model and a scoreboard of expected bus events, that the old byte appeared on the wire and the new one did not.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int REG_W = 8;
  localparam int RA_W  = 2;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} i2c_op_e;

  localparam logic [RA_W-1:0] RA_CTRL = 2'd0;
  localparam logic [RA_W-1:0] RA_STAT = 2'd1;
  localparam logic [RA_W-1:0] RA_DATA = 2'd2;
  localparam logic [RA_W-1:0] RA_RATE = 2'd3;

  localparam int CB_FLAG = 7;
  localparam int CB_ACK  = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STO  = 4;
  localparam int CB_EN   = 2;

  localparam logic [REG_W-1:0] ST_IDLE    = 8'hF8;
  localparam logic [REG_W-1:0] ST_START   = 8'h08;
  localparam logic [REG_W-1:0] ST_RSTART  = 8'h10;
  localparam logic [REG_W-1:0] ST_AW_ACK  = 8'h18;
  localparam logic [REG_W-1:0] ST_AW_NACK = 8'h20;
  localparam logic [REG_W-1:0] ST_DW_ACK  = 8'h28;
  localparam logic [REG_W-1:0] ST_DW_NACK = 8'h30;
  localparam logic [REG_W-1:0] ST_AR_ACK  = 8'h40;
  localparam logic [REG_W-1:0] ST_AR_NACK = 8'h48;
  localparam logic [REG_W-1:0] ST_DR_ACK  = 8'h50;
  localparam logic [REG_W-1:0] ST_DR_NACK = 8'h58;
  localparam logic [REG_W-1:0] ST_MASK    = 8'hF8;
endpackage

// File: rtl/i2c_cmd_clkdiv.sv
module i2c_cmd_clkdiv #(
  parameter int BR_W = 8,
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [BR_W-1:0] br_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  localparam int SHIFT_MAX = 2 * ((1 << PS_W) - 1);
  localparam int PROD_W    = BR_W + SHIFT_MAX;

  logic [PROD_W-1:0] prod, qlen, cnt_q;
  logic              wrap;

  // quarter period = 4 + br*4^ps/2, so full period = 16 + 2*br*4^ps
  assign prod = PROD_W'(br_i) << {ps_i, 1'b0};
  assign qlen = PROD_W'(4) + (prod >> 1);
  assign wrap = (cnt_q == qlen - PROD_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (wrap)        cnt_q <= '0;
    else                  cnt_q <= cnt_q + PROD_W'(1);
  end

  assign tick_o = run_i && wrap;
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  i2c_op_e       op_i,
  input  logic [DW-1:0] byte_i,
  input  logic          ack_en_i,
  input  logic          tick_i,
  input  logic          sda_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          ack_o,
  output logic [DW-1:0] rx_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  localparam int BC_W = $clog2(DW + 1);
  localparam logic [BC_W-1:0] LAST = BC_W'(DW);

  logic            busy_q, ack_en_q, ack_q, scl_q, sda_q;
  i2c_op_e         op_q;
  logic [1:0]      qtr_q;
  logic [BC_W-1:0] bit_q;
  logic [DW-1:0]   sh_q;
  logic            ack_slot;

  assign ack_slot = (bit_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      op_q     <= OP_START;
      ack_en_q <= 1'b0;
      ack_q    <= 1'b0;
      qtr_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q   <= 1'b1;
        op_q     <= op_i;
        ack_en_q <= ack_en_i;
        qtr_q    <= '0;
        bit_q    <= '0;
        sh_q     <= byte_i;
      end
    end else if (tick_i) begin
      qtr_q <= qtr_q + 2'd1;
      unique case (op_q)
        OP_START: begin
          unique case (qtr_q)
            2'd0: sda_q <= 1'b0;
            2'd1: scl_q <= 1'b0;
            2'd2: sda_q <= 1'b1;    // falling data with clock high
            2'd3: begin scl_q <= 1'b1; busy_q <= 1'b0; end
          endcase
        end
        OP_STOP: begin
          unique case (qtr_q)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b0;
            2'd2: sda_q <= 1'b0;    // rising data with clock high
            2'd3: busy_q <= 1'b0;
          endcase
        end
        default: begin
          unique case (qtr_q)
            2'd0: begin
              if (ack_slot) sda_q <= (op_q == OP_READ) ? ack_en_q : 1'b0;
              else          sda_q <= (op_q == OP_WRITE) ? ~sh_q[DW-1] : 1'b0;
            end
            2'd1: scl_q <= 1'b0;
            2'd2: begin
              if (ack_slot) ack_q <= ~sda_i;
              else          sh_q  <= {sh_q[DW-2:0], sda_i};
            end
            2'd3: begin
              scl_q <= 1'b1;
              if (ack_slot) busy_q <= 1'b0;
              else          bit_q  <= bit_q + BC_W'(1);
            end
          endcase
        end
      endcase
    end
  end

  assign done_o   = busy_q && tick_i && (qtr_q == 2'd3) &&
                    (op_q == OP_START || op_q == OP_STOP || ack_slot);
  assign busy_o   = busy_q;
  assign ack_o    = ack_q;
  assign rx_o     = sh_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int BR_W = 8,
  parameter int PS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [RA_W-1:0]  reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o
);
  logic [REG_W-1:0] ctrl_q, code_q, data_q, byte_pend_q;
  logic [BR_W-1:0]  br_q;
  logic [PS_W-1:0]  ps_q;
  logic             flag_q, go_q, ack_pend_q, was_idle_q, addr_phase_q, rd_mode_q;
  i2c_op_e          op_pend_q, op_next;
  logic             ctrl_wr, launch;
  logic             eng_busy, eng_done, eng_ack, tick;
  logic [REG_W-1:0] eng_rx;

  assign ctrl_wr = reg_we_i && (reg_addr_i == RA_CTRL);
  assign launch  = ctrl_wr && reg_wdata_i[CB_FLAG] && reg_wdata_i[CB_EN] &&
                   !eng_busy && !go_q;

  always_comb begin
    if (reg_wdata_i[CB_STA])                 op_next = OP_START;
    else if (reg_wdata_i[CB_STO])            op_next = OP_STOP;
    else if (addr_phase_q || !rd_mode_q)     op_next = OP_WRITE;
    else                                     op_next = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q       <= '0;
      flag_q       <= 1'b0;
      code_q       <= ST_IDLE;
      data_q       <= '0;
      br_q         <= '0;
      ps_q         <= '0;
      go_q         <= 1'b0;
      op_pend_q    <= OP_START;
      byte_pend_q  <= '0;
      ack_pend_q   <= 1'b0;
      was_idle_q   <= 1'b1;
      addr_phase_q <= 1'b0;
      rd_mode_q    <= 1'b0;
    end else begin
      go_q <= launch;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          RA_CTRL: begin
            ctrl_q <= reg_wdata_i & ~(REG_W'(1) << CB_FLAG);
            if (reg_wdata_i[CB_FLAG]) flag_q <= 1'b0;
          end
          RA_STAT: ps_q   <= reg_wdata_i[PS_W-1:0];
          RA_DATA: data_q <= reg_wdata_i;
          RA_RATE: br_q   <= reg_wdata_i[BR_W-1:0];
        endcase
      end
      if (launch) begin
        op_pend_q   <= op_next;
        byte_pend_q <= data_q;
        ack_pend_q  <= reg_wdata_i[CB_ACK];
        was_idle_q  <= (code_q == ST_IDLE);
      end
      if (eng_done) begin
        flag_q <= 1'b1;
        unique case (op_pend_q)
          OP_START: begin
            code_q       <= was_idle_q ? ST_START : ST_RSTART;
            addr_phase_q <= 1'b1;
          end
          OP_STOP: begin
            code_q       <= ST_IDLE;
            addr_phase_q <= 1'b0;
            rd_mode_q    <= 1'b0;
          end
          OP_WRITE: begin
            if (addr_phase_q) begin
              addr_phase_q <= 1'b0;
              rd_mode_q    <= byte_pend_q[0];
              if (byte_pend_q[0]) code_q <= eng_ack ? ST_AR_ACK : ST_AR_NACK;
              else                code_q <= eng_ack ? ST_AW_ACK : ST_AW_NACK;
            end else begin
              code_q <= eng_ack ? ST_DW_ACK : ST_DW_NACK;
            end
          end
          OP_READ: begin
            data_q <= eng_rx;
            code_q <= ack_pend_q ? ST_DR_ACK : ST_DR_NACK;
          end
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      RA_CTRL: reg_rdata_o = ctrl_q | (REG_W'(flag_q) << CB_FLAG);
      RA_STAT: reg_rdata_o = (code_q & ST_MASK) | REG_W'(ps_q);
      RA_DATA: reg_rdata_o = data_q;
      default: reg_rdata_o = REG_W'(br_q);
    endcase
  end

  i2c_cmd_clkdiv #(.BR_W(BR_W), .PS_W(PS_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (eng_busy),
    .br_i  (br_q),
    .ps_i  (ps_q),
    .tick_o(tick)
  );

  i2c_cmd_engine #(.DW(REG_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go_q),
    .op_i    (op_pend_q),
    .byte_i  (byte_pend_q),
    .ack_en_i(ack_pend_q),
    .tick_i  (tick),
    .sda_i   (sda_i),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .ack_o   (eng_ack),
    .rx_o    (eng_rx),
    .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o)
  );

  assign irq_o = flag_q;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
  import i2c_cmd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [RA_W-1:0]  reg_addr_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             irq_o,
  input logic             scl_oe_o,
  input logic             sda_oe_o,
  input logic             busy_i,
  input i2c_op_e          op_i,
  input logic [REG_W-1:0] code_i
);
  AST_FLAG_CLEARED_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(reg_we_i && reg_addr_i == RA_CTRL && reg_wdata_i[CB_FLAG])); // R1

  AST_ACTION_AFTER_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(reg_we_i && reg_addr_i == RA_CTRL &&
                            reg_wdata_i[CB_FLAG] && reg_wdata_i[CB_EN], 2)); // R2

  AST_STOP_FREES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && code_i == ST_IDLE) |-> (!scl_oe_o && !sda_oe_o)); // R9

  AST_SCL_HELD_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && code_i != ST_IDLE) |-> scl_oe_o); // R10

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && (op_i == OP_WRITE || op_i == OP_READ) && !$stable(sda_oe_o))
      |-> (scl_oe_o && $past(scl_oe_o))); // R12
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .scl_oe_o   (scl_oe_o),
  .sda_oe_o   (sda_oe_o),
  .busy_i     (eng_busy),
  .op_i       (op_pend_q),
  .code_i     (code_q)
);

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
  localparam int EV_START = 256;
  localparam int EV_STOP  = 512;
  localparam int EV_READ  = 768;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, scl_oe, sda_oe;
  logic       slv_pull = 1'b0;
  wire        scl_line = ~scl_oe;
  wire        sda_line = ~(sda_oe | slv_pull);

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  int cyc = 0, last_rel = 0, per = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  i2c_cmd_master u_i2c_cmd_master (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor side of the scoreboard
  task automatic observe(int v);
    if (exp_q.size() == 0) chk(0, "bus event R12 (unexpected)", v, -1);
    else begin
      int e = exp_q.pop_front();
      chk(v == e, "bus event R2/R3/R6/R7/R8", v, e);
    end
  endtask

  // slave model; a stray START/STOP inside a byte shows up as a scoreboard mismatch (R12)
  bit ack_addr = 1'b1, ack_data = 1'b1;
  int bitc = 0, rd_idx = 0;
  bit first = 1'b0, rd = 1'b0, mack = 1'b0;
  logic [7:0] rsh = 8'h00, txsh = 8'h00;

  task automatic load_tx();
    txsh = (rd_idx == 0) ? 8'hC3 : 8'h3C;
    rd_idx++;
    slv_pull = ~txsh[7];
    txsh = {txsh[6:0], 1'b0};
  endtask

  always @(negedge sda_line)
    if (rst_ni && scl_line === 1'b1) begin
      bitc = 0; first = 1'b1; rd = 1'b0; rd_idx = 0; slv_pull = 1'b0;
      observe(EV_START);
    end

  always @(posedge sda_line)
    if (rst_ni && scl_line === 1'b1) begin
      first = 1'b0;
      observe(EV_STOP);
    end

  always @(posedge scl_line)
    if (rst_ni) begin
      if (bitc < 8) begin
        rsh = {rsh[6:0], sda_line};
        bitc++;
        if (bitc == 8 && (first || !rd)) begin
          observe(int'(rsh));
          if (first) rd = rsh[0];
        end
      end else if (bitc == 8) begin
        bitc = 9;
        if (rd && !first) begin
          mack = ~sda_line;
          observe(EV_READ | int'(mack));
        end
      end
    end

  always @(negedge scl_line)
    if (rst_ni) begin
      if (bitc == 8) begin
        slv_pull = (first || !rd) ? (first ? ack_addr : ack_data) : 1'b0;
      end else if (bitc == 9) begin
        bitc = 0;
        if (first) begin
          first = 1'b0;
          if (rd && ack_addr) load_tx(); else slv_pull = 1'b0;
        end else if (rd && mack) load_tx();
        else slv_pull = 1'b0;
      end else if (rd && !first && bitc >= 1 && bitc <= 7) begin
        slv_pull = ~txsh[7];
        txsh = {txsh[6:0], 1'b0};
      end
    end

  always @(negedge scl_oe)
    if (rst_ni) begin
      per = cyc - last_rel;
      last_rel = cyc;
    end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_flag(string req);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    chk(irq == 1'b1, req, int'(irq), 1);
  endtask

  task automatic expect_stat(logic [7:0] e, string req);
    logic [7:0] v;
    rd_reg(2'd1, v);
    chk(v == e, req, v, e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // reset state
    rd_reg(2'd1, v); chk(v == 8'hF8, "R4 reset status", v, 8'hF8);
    rd_reg(2'd0, v); chk(v == 8'h00, "R1 reset ctrl", v, 8'h00);
    chk(!irq && !scl_oe && !sda_oe, "R9 reset lines", {irq, scl_oe, sda_oe}, 0);
    rst_ni = 1'b1;
    wr(2'd3, 8'd0); wr(2'd1, 8'd0);

    // launch gating: missing flag, then missing enable
    wr(2'd0, 8'h24); repeat (100) @(negedge clk);
    chk(!irq && !scl_oe && !sda_oe, "R1 no flag bit", {irq, scl_oe, sda_oe}, 0);
    wr(2'd0, 8'hA0); repeat (100) @(negedge clk);
    chk(!irq && !scl_oe && !sda_oe, "R1 no enable bit", {irq, scl_oe, sda_oe}, 0);

    // START from idle, with STOP also requested
    exp_q.push_back(EV_START);
    wr(2'd0, 8'hB4); wait_flag("R10 start flag");
    expect_stat(8'h08, "R5 start from idle / R3 priority");

    // write address
    wr(2'd2, 8'h44);
    exp_q.push_back(8'h44);
    wr(2'd0, 8'h84);
    rd_reg(2'd0, v); chk(v[7] == 1'b0, "R1 flag cleared", v[7], 0);
    wait_flag("R10 address flag");
    expect_stat(8'h18, "R6 write address ack");
    chk(per == 16, "R11 period br=0 ps=0", per, 16);
    begin
      bit held = 1'b1;
      repeat (40) begin @(negedge clk); if (!scl_oe) held = 1'b0; end
      chk(held, "R10 clock held low", held, 1);
    end

    // launch then overwrite data on the load edge
    wr(2'd2, 8'h55);
    exp_q.push_back(8'h55);
    @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'h84;
    @(negedge clk); addr = 2'd2; wdata = 8'hAA;
    @(negedge clk); we = 1'b0;
    wait_flag("R10 data flag");
    expect_stat(8'h28, "R7 data ack / R2 snapshot");

    // data NACK
    ack_data = 1'b0;
    wr(2'd2, 8'h0F); exp_q.push_back(8'h0F);
    wr(2'd0, 8'h84); wait_flag("R10 nack flag");
    expect_stat(8'h30, "R7 data nack");
    ack_data = 1'b1;

    // repeated START, read address
    exp_q.push_back(EV_START);
    wr(2'd0, 8'hA4); wait_flag("R10 rstart flag");
    expect_stat(8'h10, "R5 repeated start");
    wr(2'd2, 8'h45); exp_q.push_back(8'h45);
    wr(2'd0, 8'h84); wait_flag("R10 read address flag");
    expect_stat(8'h40, "R6 read address ack");

    // two reads: ACK then NACK
    exp_q.push_back(EV_READ | 1);
    wr(2'd0, 8'hC4); wait_flag("R10 read flag");
    expect_stat(8'h50, "R8 read with ack");
    rd_reg(2'd2, v); chk(v == 8'hC3, "R8 received byte", v, 8'hC3);
    exp_q.push_back(EV_READ);
    wr(2'd0, 8'h84); wait_flag("R10 read flag");
    expect_stat(8'h58, "R8 read with nack");
    rd_reg(2'd2, v); chk(v == 8'h3C, "R8 received byte", v, 8'h3C);

    // STOP wins over transfer
    exp_q.push_back(EV_STOP);
    wr(2'd0, 8'h94); wait_flag("R9 stop flag");
    expect_stat(8'hF8, "R9 stop status / R3 priority");
    chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);

    // slower clock, address NACK in both directions
    wr(2'd3, 8'd3); wr(2'd1, 8'd1);
    expect_stat(8'hF9, "R4 prescaler readback");
    ack_addr = 1'b0;
    exp_q.push_back(EV_START);
    wr(2'd0, 8'hA4); wait_flag("R10 start flag");
    expect_stat(8'h09, "R5 start from idle");
    wr(2'd2, 8'h44); exp_q.push_back(8'h44);
    wr(2'd0, 8'h84); wait_flag("R10 address flag");
    expect_stat(8'h21, "R6 write address nack");
    chk(per == 40, "R11 period br=3 ps=1", per, 40);
    exp_q.push_back(EV_START);
    wr(2'd0, 8'hA4); wait_flag("R10 rstart flag");
    wr(2'd2, 8'h45); exp_q.push_back(8'h45);
    wr(2'd0, 8'h84); wait_flag("R10 address flag");
    expect_stat(8'h49, "R6 read address nack");
    exp_q.push_back(EV_STOP);
    wr(2'd0, 8'h94); wait_flag("R9 stop flag");
    expect_stat(8'hF9, "R9 stop status");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule